// File: doc/BRIEF.md
# DRAM Fast-Page Access Sequencer

This block turns single-word requests into the strobe sequence of an asynchronous DRAM whose row and column addresses share one set of address pins. Each request gives an address, a read/write flag, write data and a flag saying whether the address lies in DRAM space. The block drives the shared address bus, the row strobe (active low), the column strobe (active low) and the write strobe (active low). It returns read data together with a one-clock acknowledge.

A full access puts the row on the bus with the row strobe, then the column with the column strobe. When page reuse is enabled and the request's row matches the row still held open, only the column phase runs. Read and write column phases each have their own pitch, short or long. A hold option decides whether a request outside DRAM space closes the open row or leaves it open. Configuration comes from static inputs. A caller issues one request at a time, as a one-clock `req_valid` pulse while the block is idle, and then waits for `ack`.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset `dram_ras_n`, `dram_cas_n`, `dram_we_n` are 1 and `ack`, `dram_dq_oe` are 0. After reset, and after any release of the row strobe, the next DRAM access is a full access.
- R2: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. Both are driven on `dram_addr`, zero-extended: the row while the row strobe first falls, the column while `dram_cas_n` is 0.
- R3: With `cfg_burst_en`=0, every DRAM access is a full access. The row strobe falls once and is released in the cycle `ack` is seen. With short pitch, `ack` is seen 3 clocks after the request edge.
- R4: With `cfg_burst_en`=1 and a request row equal to the open row, the row strobe stays low and only a column phase runs. With short pitch, `ack` is seen 2 clocks after the request edge.
- R5: A DRAM request whose row misses while the row strobe is low drives the row strobe high for exactly one precharge clock, then runs a full access. With short pitch, `ack` is seen 4 clocks after the request edge.
- R6: The column strobe stays low for 1 clock with short pitch and 2 clocks with long pitch. `cfg_rd_long` sets the pitch for reads and `cfg_wr_long` sets it for writes, both sampled when the request is accepted.
- R7: For a write, `dram_we_n` is 0 and `dram_dq_oe` is 1 while the column strobe is low, with `dram_dq_out` equal to the request's write data. For a read, `rd_data` takes `dram_dq_in` on the last column clock and is valid while `ack` is 1.
- R8: `ack` is a single-clock pulse per request.
- R9: A request with `req_dram`=0 is acknowledged 1 clock after the request edge, with no column strobe activity.
- R10: With `cfg_ras_down`=1, a request outside DRAM space leaves the row strobe low, and a later same-row DRAM access still runs as a page access.
- R11: With `cfg_ras_down`=0, a request outside DRAM space releases the row strobe, and the next DRAM access is a full access.
- R12: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request pulse, accepted while idle |
| req_addr | input | ROW_W+COL_W | Request address, row in the upper bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_dram | input | 1 | 1 = address lies in DRAM space |
| cfg_burst_en | input | 1 | Enable reuse of the open row on a hit |
| cfg_rd_long | input | 1 | Long column pitch for reads |
| cfg_wr_long | input | 1 | Long column pitch for writes |
| cfg_ras_down | input | 1 | Keep the row open across requests outside DRAM space |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Write data to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Read data from the DRAM |
| rd_data | output | DATA_W | Captured read data |
| ack | output | 1 | Request complete, one-clock pulse |

## Verification
Counted from the clock edge that samples `req_valid`, `ack` appears 1 clock later for a request outside DRAM space, 2 for a short page hit, 3 for a short full access, and 4 for a miss that needs precharge. Each long column phase adds 1 clock. The bench drives each request just after a falling edge and then, at every falling edge, counts clocks until `ack`. It compares that count with the expected latency for the case. A monitor that samples at falling edges counts row-strobe falls and column-strobe clocks, and records the address and write data seen during those phases. Each task compares those totals, taken over the whole access, and checks `rd_data` and the row strobe level in the `ack` cycle.

// File: rtl/dpc_pkg.sv
// Shared types for the DRAM page-mode access sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_PRE  = 2'd1,   // row strobe released for precharge
        ST_ROW  = 2'd2,   // row address strobed
        ST_COL  = 2'd3    // column address strobed
    } dpc_state_e;
endpackage

// File: rtl/dpc_row_track.sv
// Open-row tracker: remembers the row last strobed and whether it is still open.
// Assumes: load and clear are never asserted together by the sequencer.
module dpc_row_track #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,      // a new row is being strobed
    input  logic [ROW_W-1:0] load_row,
    input  logic             clear,     // row strobe is being released
    input  logic [ROW_W-1:0] cmp_row,   // row of the incoming request
    output logic             hit,
    output logic             valid
);
    logic [ROW_W-1:0] row_q;
    logic             valid_q;

    // Hold the stored row and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            valid_q <= 1'b0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (load) begin
            row_q   <= load_row;
            valid_q <= 1'b1;
        end
    end

    // Compare the incoming row against the stored one.
    always_comb begin
        hit   = valid_q && (row_q == cmp_row);
        valid = valid_q;
    end

    // R1: a release leaves no stale row behind.
    p_clear_drops_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !valid_q);
endmodule

// File: rtl/dpc_seq.sv
// Access sequencer: chooses full, page or precharge-then-full sequences,
// times the column phase and owns the row strobe state.
// Assumes: req_valid is only meaningful in ST_IDLE; configuration is static
// during an access.
module dpc_seq
    import dpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_dram,
    input  logic       row_hit,
    input  logic       cfg_burst_en,
    input  logic       cfg_rd_long,
    input  logic       cfg_wr_long,
    input  logic       cfg_ras_down,
    output dpc_state_e state,
    output logic       ras_open,
    output logic       accept,     // request latched this cycle
    output logic       col_last,   // final column clock
    output logic       row_drop,   // row strobe being released
    output logic       ack
);
    dpc_state_e state_q, state_d;
    logic       ras_q, ras_d;
    logic       ack_q, ack_d;
    logic       long_q, long_d;
    logic       cnt_q, cnt_d;

    // Next-state, row strobe and pitch decisions.
    always_comb begin
        state_d  = state_q;
        ras_d    = ras_q;
        ack_d    = 1'b0;
        long_d   = long_q;
        cnt_d    = cnt_q;
        accept   = 1'b0;
        col_last = (state_q == ST_COL) && (!long_q || cnt_q);
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    long_d = req_write ? cfg_wr_long : cfg_rd_long;
                    cnt_d  = 1'b0;
                    if (!req_dram) begin
                        ack_d = 1'b1;
                        if (!cfg_ras_down) ras_d = 1'b0;
                    end else if (cfg_burst_en && ras_q && row_hit) begin
                        state_d = ST_COL;
                    end else if (ras_q) begin
                        ras_d   = 1'b0;
                        state_d = ST_PRE;
                    end else begin
                        ras_d   = 1'b1;
                        state_d = ST_ROW;
                    end
                end
            end
            ST_PRE: begin
                ras_d   = 1'b1;
                state_d = ST_ROW;
            end
            ST_ROW: state_d = ST_COL;
            ST_COL: begin
                if (col_last) begin
                    ack_d   = 1'b1;
                    state_d = ST_IDLE;
                    if (!cfg_burst_en) ras_d = 1'b0;
                end else begin
                    cnt_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        row_drop = ras_q && !ras_d;
    end

    // Register state, row strobe, pitch and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ras_q   <= 1'b0;
            ack_q   <= 1'b0;
            long_q  <= 1'b0;
            cnt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ras_q   <= ras_d;
            ack_q   <= ack_d;
            long_q  <= long_d;
            cnt_q   <= cnt_d;
        end
    end

    // Drive outputs from the registers.
    always_comb begin
        state    = state_q;
        ras_open = ras_q;
        ack      = ack_q;
    end

    // R3: with reuse off, a DRAM request never skips the row phase.
    p_full_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && req_dram && !cfg_burst_en)
        |=> (state_q != ST_COL));
    // R5: precharge lasts one clock and is followed by the row phase.
    p_precharge_one_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE) |=> (state_q == ST_ROW && ras_q));
    // R8: acknowledge is a single-clock pulse.
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);
    // R10: hold mode keeps the row open over a request outside DRAM space.
    p_hold_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !req_dram && cfg_ras_down && ras_q)
        |=> ras_q);
    // R11: release mode closes the row on a request outside DRAM space.
    p_release_row_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !req_dram && !cfg_ras_down)
        |=> !ras_q);
endmodule

// File: rtl/dram_page_ctrl.sv
// DRAM fast-page access sequencer top: latches the request, multiplexes
// row/column onto the shared address pins and captures read data.
// Assumes: one request in flight; caller waits for ack before the next one.
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_dram,
    input  logic              cfg_burst_en,
    input  logic              cfg_rd_long,
    input  logic              cfg_wr_long,
    input  logic              cfg_ras_down,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack
);
    dpc_state_e        state;
    logic              ras_open, accept, col_last, row_drop;
    logic              row_hit, row_valid;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q, rd_q;

    dpc_row_track #(.ROW_W(ROW_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_ROW),
        .load_row (row_q),
        .clear    (row_drop),
        .cmp_row  (req_addr[ADDR_W-1:COL_W]),
        .hit      (row_hit),
        .valid    (row_valid)
    );

    dpc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_dram     (req_dram),
        .row_hit      (row_hit),
        .cfg_burst_en (cfg_burst_en),
        .cfg_rd_long  (cfg_rd_long),
        .cfg_wr_long  (cfg_wr_long),
        .cfg_ras_down (cfg_ras_down),
        .state        (state),
        .ras_open     (ras_open),
        .accept       (accept),
        .col_last     (col_last),
        .row_drop     (row_drop),
        .ack          (ack)
    );

    // Latch the request fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            row_q   <= req_addr[ADDR_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data on the final column clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_q <= '0;
        else if (col_last && !wr_q)   rd_q <= dram_dq_in;
    end

    // Drive the DRAM pins from the sequencer state.
    always_comb begin
        dram_addr   = (state == ST_COL) ? MUX_W'(col_q) : MUX_W'(row_q);
        dram_ras_n  = !ras_open;
        dram_cas_n  = (state != ST_COL);
        dram_we_n   = !((state == ST_COL) && wr_q);
        dram_dq_oe  = (state == ST_COL) && wr_q;
        dram_dq_out = wdata_q;
        rd_data     = rd_q;
    end

    // R12: column strobe only under an open row.
    p_cas_under_ras_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    // R4: a stored row is only kept while the row strobe is low.
    p_valid_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> ras_open);
    // R7: data is driven only together with the write strobe.
    p_oe_with_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> !dram_we_n && !dram_cas_n);
endmodule

// File: tb/test_dram_page_ctrl.sv
// Directed bench for dram_page_ctrl; one task per scenario.
module test_dram_page_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_dram = 1'b0;
    logic        cfg_burst_en = 1'b0, cfg_rd_long = 1'b0;
    logic        cfg_wr_long = 1'b0, cfg_ras_down = 1'b0;
    logic [7:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, ack;
    logic [15:0] dram_dq_out, dram_dq_in, rd_data;

    int n_chk = 0, n_bad = 0;
    int ras_falls = 0, cas_clks = 0, cas_bad = 0;
    logic       prev_ras_n = 1'b1;
    logic [7:0] row_seen = '0, wr_col = '0;
    logic [15:0] wr_dat = '0;

    always #10 clk = ~clk;   // 50 MHz

    assign dram_dq_in = {8'hA5, dram_addr};

    dram_page_ctrl i_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_dram(req_dram),
        .cfg_burst_en(cfg_burst_en), .cfg_rd_long(cfg_rd_long),
        .cfg_wr_long(cfg_wr_long), .cfg_ras_down(cfg_ras_down),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in), .rd_data(rd_data), .ack(ack)
    );

    // Pin monitor, sampled at falling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras_n && !dram_ras_n) begin
                ras_falls++;
                row_seen = dram_addr;
            end
            if (!dram_cas_n) begin
                cas_clks++;
                if (dram_ras_n) cas_bad++;
                if (!dram_we_n && dram_dq_oe) begin
                    wr_col = dram_addr;
                    wr_dat = dram_dq_out;
                end
            end
        end
        prev_ras_n = dram_ras_n;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One request; checks latency, strobe counts, row strobe level and data.
    task automatic access(input logic [15:0] addr, input logic wr,
                          input logic [15:0] wd, input logic dram,
                          input int exp_cyc, input int exp_falls,
                          input int exp_cas, input logic exp_ras_n,
                          input string tag);
        int f0, c0, cyc;
        @(negedge clk); #1;
        req_addr = addr; req_write = wr; req_wdata = wd; req_dram = dram;
        req_valid = 1'b1;
        f0 = ras_falls; c0 = cas_clks; cyc = 0;
        do begin
            @(negedge clk); #1;
            cyc++;
            if (cyc == 1) req_valid = 1'b0;
        end while (!ack && cyc < 20);
        chk({tag, " latency"}, cyc, exp_cyc);
        chk({tag, " row strobe falls"}, ras_falls - f0, exp_falls);
        chk({tag, " column clocks"}, cas_clks - c0, exp_cas);
        chk({tag, " row strobe after"}, int'(dram_ras_n), int'(exp_ras_n));
        if (dram && !wr) chk({tag, " R7 read data"}, rd_data, {8'hA5, addr[7:0]});
        if (dram && wr) begin
            chk({tag, " R7 write column"}, wr_col, addr[7:0]);
            chk({tag, " R7 write data"}, wr_dat, wd);
        end
        if (exp_falls == 1) chk({tag, " R2 row address"}, row_seen, addr[15:8]);
        @(negedge clk); #1;
        chk({tag, " R8 ack pulse"}, int'(ack), 0);
    endtask

    task automatic t_reset;
        chk("R1 ras_n", int'(dram_ras_n), 1);
        chk("R1 cas_n", int'(dram_cas_n), 1);
        chk("R1 we_n",  int'(dram_we_n), 1);
        chk("R1 ack",   int'(ack), 0);
        chk("R1 oe",    int'(dram_dq_oe), 0);
    endtask

    task automatic t_burst_off;   // R3
        cfg_burst_en = 0; cfg_rd_long = 0; cfg_wr_long = 0; cfg_ras_down = 0;
        access(16'h0305, 0, 16'h0, 1, 3, 1, 1, 1, "R3 first full read");
        access(16'h0306, 0, 16'h0, 1, 3, 1, 1, 1, "R3 same row still full");
        access(16'h0307, 1, 16'h1234, 1, 3, 1, 1, 1, "R3 full write");
    endtask

    task automatic t_burst_hits;  // R1 R4 R6
        cfg_burst_en = 1; cfg_wr_long = 1;
        access(16'h0701, 0, 16'h0, 1, 3, 1, 1, 0, "R1 full after release");
        access(16'h0702, 0, 16'h0, 1, 2, 0, 1, 0, "R4 page hit read");
        access(16'h0703, 1, 16'hBEEF, 1, 3, 0, 2, 0, "R6 long write hit");
    endtask

    task automatic t_miss;        // R5
        access(16'h0900, 0, 16'h0, 1, 4, 1, 1, 0, "R5 miss with precharge");
    endtask

    task automatic t_hold;        // R9 R10
        cfg_ras_down = 1;
        access(16'h1234, 0, 16'h0, 0, 1, 0, 0, 0, "R9 R10 outside space held");
        access(16'h0904, 0, 16'h0, 1, 2, 0, 1, 0, "R10 page hit after hold");
    endtask

    task automatic t_release;     // R11
        cfg_ras_down = 0;
        access(16'h5678, 1, 16'h0, 0, 1, 0, 0, 1, "R11 outside space released");
        access(16'h0905, 0, 16'h0, 1, 3, 1, 1, 0, "R11 full after release");
    endtask

    task automatic t_pitch;       // R6
        cfg_rd_long = 1; cfg_wr_long = 0;
        access(16'h0906, 0, 16'h0, 1, 3, 0, 2, 0, "R6 long read hit");
        access(16'h0907, 1, 16'hC3C3, 1, 2, 0, 1, 0, "R6 short write hit");
        chk("R12 column strobe under row strobe", cas_bad, 0);
    endtask

    initial begin
        #200000;   // 10,000 clocks
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset;
        t_burst_off;
        t_burst_hits;
        t_miss;
        t_hold;
        t_release;
        t_pitch;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule